// File: doc/BRIEF.md
# Memory Access Permission Checker

This block decides whether a memory access that has already found its translation must be refused because of that translation's access-permission code. It takes the permission code of the matched entry (two base bits plus an extension bit that makes a region read-only), the privilege level and the write flag of the access, and two system-control inputs: the extended page table enable and a 2-bit legacy protection selector. It returns an abort flag and a fault code.

The decisive corner is permission code 0. With the extended page table enable set, that code refuses every access. With the enable clear, the legacy selector decides instead: it can let through all reads, or privileged reads only, or nothing. The read-only extension bit counts only in extended mode and is ignored otherwise. Domain checks, access-flag handling, lookup and table walking belong to other blocks. A parameter picks either a registered output stage (the default) or a purely combinational path.

Top module: `perm_checker`

## Requirements
- R1: With the extended enable set and permission base bits 0, every access aborts, whatever the read-only extension bit.
- R2: With the extended enable clear, base bits 0 and legacy selector 2, only writes abort.
- R3: With the extended enable clear, base bits 0 and legacy selector 1, an access aborts when it is a write or when it is unprivileged.
- R4: With the extended enable clear, base bits 0 and legacy selector 0 or 3, every access aborts.
- R5: Base bits 1 with the extension bit clear abort every unprivileged access and no privileged one.
- R6: Base bits 2 with the extension bit clear abort only unprivileged writes; base bits 3 with the extension bit clear never abort.
- R7: With the extended enable set and the extension bit (permission code bit 2) set, base bits 1 abort writes and unprivileged accesses, and base bits 2 or 3 abort writes at every privilege level.
- R8: With the extended enable clear, the extension bit has no effect: each code gives the same result as the same base bits with the extension bit clear.
- R9: An abort reports fault code 4'hD, which is neither translation code (4'h5, 4'h7); an access that does not abort reports 4'h0.
- R10: With the registered stage, results appear one clock after the access is presented; an idle cycle (acc_valid low) gives out_valid low, abort low and code 0; reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| ap_code | input | 3 | Permission code: bits [1:0] base, bit 2 read-only extension |
| is_priv | input | 1 | Access made at privileged level |
| is_write | input | 1 | Access is a write |
| ext_ap_en | input | 1 | Extended page table enable |
| legacy_prot | input | 2 | Legacy protection selector, used when the enable is clear |
| out_valid | output | 1 | Result valid |
| abort | output | 1 | Access refused |
| fault_code | output | 4 | 4'hD on abort, 4'h0 otherwise |

## Verification
With the default registered stage every result is due exactly one rising edge after the access is presented. The bench drives each access on a falling edge, lets one rising edge pass, and reads the outputs at the following falling edge, so each check sees the result of one access only. After every access it drives an idle cycle and checks that the outputs return to the idle values at the next falling edge.

// File: rtl/apc_pkg.sv
package apc_pkg;
   localparam int unsigned FC_W = 4;
   typedef logic [FC_W-1:0] fcode_t;
   localparam fcode_t FC_NONE = 4'h0;
   localparam fcode_t FC_PERM = 4'hD;
   localparam fcode_t FC_XLAT_SECT = 4'h5;
   localparam fcode_t FC_XLAT_PAGE = 4'h7;

   typedef enum logic [1:0] {
      BASE_NONE  = 2'd0,
      BASE_PRIV  = 2'd1,
      BASE_URO   = 2'd2,
      BASE_FULL  = 2'd3
   } ap_base_e;
endpackage

// File: rtl/apc_ap0_legacy.sv
module apc_ap0_legacy (
   input  logic       ext_en,
   input  logic [1:0] prot_sel,
   input  logic       is_priv,
   input  logic       is_write,
   output logic       deny
);
   always_comb begin
      if (ext_en) begin
         deny = 1'b1;
      end else begin
         unique case (prot_sel)
            2'd2:    deny = is_write;
            2'd1:    deny = is_write | ~is_priv;
            default: deny = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/apc_grant.sv
module apc_grant
   import apc_pkg::*;
(
   input  logic   ext_en,
   input  logic   ro_ext,
   input  logic [1:0] base,
   input  logic   is_priv,
   input  logic   is_write,
   input  logic   zero_deny,
   output logic   deny,
   output fcode_t code
);
   logic     ro_live;
   ap_base_e b;

   assign ro_live = ext_en & ro_ext;
   assign b       = ap_base_e'(base);

   always_comb begin
      unique case (b)
         BASE_NONE: deny = zero_deny;
         BASE_PRIV: deny = ro_live ? (is_write | ~is_priv) : ~is_priv;
         BASE_URO:  deny = ro_live ? is_write : (is_write & ~is_priv);
         default:   deny = ro_live ? is_write : 1'b0;
      endcase
      code = deny ? FC_PERM : FC_NONE;
   end
endmodule

// File: rtl/perm_checker.sv
module perm_checker
   import apc_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_valid,
   input  logic [2:0] ap_code,
   input  logic       is_priv,
   input  logic       is_write,
   input  logic       ext_ap_en,
   input  logic [1:0] legacy_prot,
   output logic       out_valid,
   output logic       abort,
   output logic [3:0] fault_code
);
   if (FC_PERM == FC_NONE || FC_PERM == FC_XLAT_SECT || FC_PERM == FC_XLAT_PAGE) begin : g_bad_code
      $error("permission fault code collides with another code");
   end

   logic   zero_deny;
   logic   deny_c;
   fcode_t code_c;

   apc_ap0_legacy u_zero (
      .ext_en   (ext_ap_en),
      .prot_sel (legacy_prot),
      .is_priv  (is_priv),
      .is_write (is_write),
      .deny     (zero_deny)
   );

   apc_grant u_grant (
      .ext_en    (ext_ap_en),
      .ro_ext    (ap_code[2]),
      .base      (ap_code[1:0]),
      .is_priv   (is_priv),
      .is_write  (is_write),
      .zero_deny (zero_deny),
      .deny      (deny_c),
      .code      (code_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            abort      <= 1'b0;
            fault_code <= FC_NONE;
         end else begin
            out_valid  <= acc_valid;
            abort      <= acc_valid & deny_c;
            fault_code <= acc_valid ? code_c : FC_NONE;
         end
      end

      assert_ap0_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && ap_code[1:0] == 2'd0 && ext_ap_en |=> abort && fault_code == FC_PERM);
      assert_rs2_R2: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && ap_code[1:0] == 2'd0 && !ext_ap_en && legacy_prot == 2'd2
         |=> abort == $past(is_write));
      assert_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && ap_code == 3'd3 |=> !abort && fault_code == FC_NONE);
      assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && ext_ap_en && ap_code[2] && ap_code[1] && is_write |=> abort);
      assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_valid |=> !out_valid && !abort && fault_code == FC_NONE);
   end else begin : g_comb
      assign out_valid  = acc_valid;
      assign abort      = acc_valid & deny_c;
      assign fault_code = acc_valid ? code_c : FC_NONE;

      assert_ap0_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && ap_code[1:0] == 2'd0 && ext_ap_en |-> abort && fault_code == FC_PERM);
      assert_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && ap_code == 3'd3 |-> !abort);
      assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && ext_ap_en && ap_code[2] && ap_code[1] && is_write |-> abort);
      assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_valid |-> !out_valid && !abort);
   end
endmodule

// File: tb/sim_perm_checker.sv
module sim_perm_checker;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [2:0] ap_code = 3'd0;
   logic       is_priv = 1'b0;
   logic       is_write = 1'b0;
   logic       ext_ap_en = 1'b0;
   logic [1:0] legacy_prot = 2'd0;
   logic       out_valid;
   logic       abort;
   logic [3:0] fault_code;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   perm_checker u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .ap_code(ap_code),
      .is_priv(is_priv), .is_write(is_write), .ext_ap_en(ext_ap_en),
      .legacy_prot(legacy_prot), .out_valid(out_valid), .abort(abort),
      .fault_code(fault_code)
   );

   task automatic cmp(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got valid/abort/code=%b expected %b", req, act, exp);
      end
   endtask

   // present one access, check its result one edge later, then an idle cycle
   task automatic access(input string req, input logic x, input logic [1:0] rs,
                         input logic [2:0] ap, input logic p, input logic w, input logic exp_abort);
      @(negedge clk);
      acc_valid = 1'b1; ext_ap_en = x; legacy_prot = rs; ap_code = ap; is_priv = p; is_write = w;
      @(negedge clk);
      cmp(req, {out_valid, abort, fault_code}, {1'b1, exp_abort, exp_abort ? 4'hD : 4'h0});
      acc_valid = 1'b0;
      @(negedge clk);
      cmp("R10 idle", {out_valid, abort, fault_code}, 6'b0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      cmp("R10 reset", {out_valid, abort, fault_code}, 6'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_ext_zero();
      access("R1", 1, 2'd2, 3'b000, 1, 0, 1);
      access("R1", 1, 2'd1, 3'b000, 1, 0, 1);
      access("R1", 1, 2'd2, 3'b100, 1, 0, 1);
   endtask

   task automatic t_legacy();
      access("R2", 0, 2'd2, 3'b000, 0, 0, 0);
      access("R2", 0, 2'd2, 3'b000, 1, 1, 1);
      access("R3", 0, 2'd1, 3'b000, 1, 0, 0);
      access("R3", 0, 2'd1, 3'b000, 0, 0, 1);
      access("R3", 0, 2'd1, 3'b000, 1, 1, 1);
      access("R4", 0, 2'd0, 3'b000, 1, 0, 1);
      access("R4", 0, 2'd3, 3'b000, 1, 0, 1);
   endtask

   task automatic t_base();
      access("R5", 1, 2'd0, 3'b001, 0, 0, 1);
      access("R5", 1, 2'd0, 3'b001, 1, 1, 0);
      access("R6", 1, 2'd0, 3'b010, 0, 1, 1);
      access("R6", 1, 2'd0, 3'b010, 0, 0, 0);
      access("R6", 1, 2'd0, 3'b010, 1, 1, 0);
      access("R6", 0, 2'd0, 3'b011, 0, 1, 0);
   endtask

   task automatic t_readonly();
      access("R7", 1, 2'd0, 3'b101, 1, 1, 1);
      access("R7", 1, 2'd0, 3'b101, 0, 0, 1);
      access("R7", 1, 2'd0, 3'b101, 1, 0, 0);
      access("R7", 1, 2'd0, 3'b110, 1, 1, 1);
      access("R7", 1, 2'd0, 3'b111, 0, 0, 0);
      access("R7", 1, 2'd0, 3'b111, 1, 1, 1);
   endtask

   task automatic t_ext_ignored();
      access("R8", 0, 2'd0, 3'b111, 1, 1, 0);
      access("R8", 0, 2'd0, 3'b110, 1, 1, 0);
      access("R8", 0, 2'd0, 3'b101, 1, 1, 0);
      access("R8", 0, 2'd2, 3'b100, 0, 0, 0);
   endtask

   initial begin
      t_reset();
      t_ext_zero();
      t_legacy();
      t_base();
      t_readonly();
      t_ext_ignored();
      // R9 is covered by the code field compared in every access above
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule